// File: doc/BRIEF.md
# Stereo Shift-and-Add Interpolation Filter

This block raises the sample rate of a signed stereo audio stream by a fixed factor of 4·R (128 with the default R = 32) before it reaches a noise-shaping modulator. Four filter stages run in a fixed cascade. A three-tap equalizer at the input rate lifts the upper band to offset the droop of the last stage. Two half-band stages each double the rate. A second-order comb stage (two combs at its input rate, two integrators at its output rate) multiplies the rate by R. Every coefficient product is built from shifts and additions. No multiplier is used.

Each stage holds one input sample and passes data on through a valid/ready pair, so back-pressure at the output reaches the input. Words grow at full width through the cascade. A single rounding and saturation step at the end brings both channels back to the output width. Both channels share one set of handshakes and move in lockstep.

Top module: `interp_chain`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid is 0, in_ready is 1, and every filter history register reads as zero. The next stream therefore starts from silence.
- R2: Each accepted input sample yields exactly 4·R output samples per channel, in order. After the last input, out_valid stays low. While the comb stage has outputs of a sample still to emit, its phase counter advances by one on each output transfer.
- R3: The equalizer computes e[n] = 10·x[n-1] − x[n] − x[n-2], which carries a scale of 8. It is built from shifts and adds.
- R4: Each half-band stage turns input u[k] into two outputs, first 16·u[k-2], then 9·(u[k-1]+u[k-2]) − (u[k]+u[k-3]), which carries a scale of 16. A first output is always followed by its second output.
- R5: The comb stage turns input w[k] into R outputs, y = (j+1)·w[k] + (R−1−j)·w[k−1] for phase j = 0..R−1, which carries a scale of R.
- R6: The output is the full-width result divided by 2^F, with F = 3 + 4 + 4 + log2(R). The division rounds half up, computed as (v + 2^(F−1)) shifted right arithmetically by F. History before reset counts as zero.
- R7: A rounded result above 2^(OUT_W−1)−1 saturates to 131071. A result below −2^(OUT_W−1) saturates to −131072. Neither wraps.
- R8: A constant input held long enough comes out unchanged (unity DC gain).
- R9: While out_valid is 1 and out_ready is 0, out_valid and both output words hold. A stall that lasts long enough drives in_ready low. No sample is lost or duplicated.
- R10: The left channel (lane 0) and the right channel (lane 1) are filtered independently with identical arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An input stereo sample is offered |
| in_ready | output | 1 | The block accepts the offered sample this cycle |
| in_left | input | IN_W | Left input sample, two's complement |
| in_right | input | IN_W | Right input sample, two's complement |
| out_valid | output | 1 | An oversampled stereo sample is presented |
| out_ready | input | 1 | Downstream takes the presented sample |
| out_left | output | OUT_W | Left output sample, rounded and saturated |
| out_right | output | OUT_W | Right output sample, rounded and saturated |

## Verification
A corrupted history register in any stage shows up as an error in the output stream within a few input samples. The equalizer and half-band windows span at most four samples, so a bad value leaves the data path once four newer samples have shifted in, and the comb stage carries a bad integrator value until the next reset. A phase or handshake fault shows up as a shift in output count. One output too many or too few moves every later sample against the expected stream, and the run ends with the wrong total. Stall handling is checked by holding out_ready low for hundreds of cycles, then comparing every sample and the total.

// File: rtl/interp_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interpolation cascade: per-stage word growth
// and the fractional bits each stage adds to the full-width result.
package interp_pkg;
    localparam int DROOP_GROWTH = 4;   // |10| + |1| + |1| = 12 -> 4 bits
    localparam int DROOP_FRAC   = 3;   // coefficient scale of 8
    localparam int HB_GROWTH    = 5;   // 9 + 9 + 1 + 1 = 20 -> 5 bits
    localparam int HB_FRAC      = 4;   // coefficient scale of 16
endpackage

// File: rtl/droop_eq.sv
`timescale 1ns/1ps
// Three-tap symmetric equalizer at the input rate.
// Computes 10*x[n-1] - x[n] - x[n-2] (gain 8) per lane with shifts and adds.
// Assumes OW >= IW + 4; history is cleared by reset; one-sample output register.
module droop_eq #(
    parameter int CH = 2,
    parameter int IW = 18,
    parameter int OW = IW + interp_pkg::DROOP_GROWTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CH*IW-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CH*OW-1:0] out_data
);
    logic vld;
    logic in_fire;

    assign in_ready  = !vld || out_ready;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = vld;

    // Output occupancy: set on accept, cleared when taken with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n)       vld <= 1'b0;
        else if (in_fire) vld <= 1'b1;
        else if (out_ready) vld <= 1'b0;
    end

    for (genvar c = 0; c < CH; c++) begin : g_lane
        logic signed [OW-1:0] x_e, h1, h2, y, acc;
        assign x_e = {{(OW-IW){in_data[c*IW+IW-1]}}, in_data[c*IW +: IW]};
        assign acc = (h1 <<< 3) + (h1 <<< 1) - x_e - h2;

        // Shift the two-sample history and register the filtered value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                h1 <= '0;
                h2 <= '0;
                y  <= '0;
            end else if (in_fire) begin
                h2 <= h1;
                h1 <= x_e;
                y  <= acc;
            end
        end
        assign out_data[c*OW +: OW] = y;
    end

    // R9: a presented but untaken result holds.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/halfband_x2.sv
`timescale 1ns/1ps
// Half-band 2x interpolator, taps (-1, 0, 9, 16, 9, 0, -1)/16 in polyphase form.
// Per accepted sample emits 16*u[k-2], then 9*(u[k-1]+u[k-2]) - (u[k]+u[k-3]).
// Assumes OW >= IW + 5; window cleared by reset.
module halfband_x2 #(
    parameter int CH = 2,
    parameter int IW = 22,
    parameter int OW = IW + interp_pkg::HB_GROWTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CH*IW-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CH*OW-1:0] out_data
);
    logic full;
    logic ph;
    logic in_fire, out_fire;

    assign out_valid = full;
    assign out_fire  = full && out_ready;
    assign in_ready  = !full || (ph && out_ready);
    assign in_fire   = in_valid && in_ready;

    // Phase control: two outputs per held sample, then free the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            ph   <= 1'b0;
        end else if (in_fire) begin
            full <= 1'b1;
            ph   <= 1'b0;
        end else if (out_fire) begin
            if (ph) full <= 1'b0;
            else    ph   <= 1'b1;
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_lane
        logic signed [OW-1:0] x_e, d0, d1, d2, d3, s12, odd_v, ctr_v;
        assign x_e   = {{(OW-IW){in_data[c*IW+IW-1]}}, in_data[c*IW +: IW]};
        assign s12   = d1 + d2;
        assign odd_v = (s12 <<< 3) + s12 - d0 - d3;
        assign ctr_v = d2 <<< 4;

        // Four-sample window shifts on every accepted input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d0 <= '0; d1 <= '0; d2 <= '0; d3 <= '0;
            end else if (in_fire) begin
                d3 <= d2; d2 <= d1; d1 <= d0; d0 <= x_e;
            end
        end
        assign out_data[c*OW +: OW] = ph ? odd_v : ctr_v;
    end

    // R4: a first-phase output is always followed by its second phase.
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && !ph |=> out_valid && ph);
endmodule

// File: rtl/comb2_interp.sv
`timescale 1ns/1ps
// Second-order comb interpolator by R: two combs at the input rate, a
// zero-stuffed impulse per input, two integrators at the output rate.
// Gain is R. Assumes R is a power of two >= 2 and OW >= IW + log2(R) + 2.
module comb2_interp #(
    parameter int CH = 2,
    parameter int IW = 32,
    parameter int R  = 32,
    parameter int OW = IW + $clog2(R) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CH*IW-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CH*OW-1:0] out_data
);
    localparam int RL = $clog2(R);
    localparam logic [RL-1:0] LAST = RL'(R - 1);

    logic          full;
    logic [RL-1:0] j;
    logic          in_fire, out_fire;

    assign out_valid = full;
    assign out_fire  = full && out_ready;
    assign in_ready  = !full || (out_ready && j == LAST);
    assign in_fire   = in_valid && in_ready;

    // Phase counter: R outputs per held sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            j    <= '0;
        end else if (in_fire) begin
            full <= 1'b1;
            j    <= '0;
        end else if (out_fire) begin
            if (j == LAST) full <= 1'b0;
            else           j    <= j + RL'(1);
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_lane
        logic signed [OW-1:0] x_e, x0, x1, x2, c2, inj, i1, i2, i1n, y;
        assign x_e = {{(OW-IW){in_data[c*IW+IW-1]}}, in_data[c*IW +: IW]};
        assign c2  = x0 - (x1 <<< 1) + x2;
        assign inj = (j == '0) ? c2 : '0;
        assign i1n = i1 + inj;
        assign y   = i2 + i1n;

        // Comb delay line at the input rate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x0 <= '0; x1 <= '0; x2 <= '0;
            end else if (in_fire) begin
                x2 <= x1; x1 <= x0; x0 <= x_e;
            end
        end

        // Integrators commit on each output transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                i1 <= '0; i2 <= '0;
            end else if (out_fire) begin
                i1 <= i1n;
                i2 <= y;
            end
        end
        assign out_data[c*OW +: OW] = y;
    end

    // R2: mid-sample outputs step the phase by exactly one.
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && j != LAST && !in_fire |=> full && j == $past(j) + RL'(1));
endmodule

// File: rtl/interp_chain.sv
`timescale 1ns/1ps
// Stereo interpolation cascade: equalizer, two half-band x2 stages, and a
// second-order comb xR, then one round-half-up and saturate step per lane.
// Lane 0 is left, lane 1 right. Assumes R is a power of two >= 2.
module interp_chain #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 18,
    parameter int R     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_left,
    input  logic [IN_W-1:0]  in_right,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_left,
    output logic [OUT_W-1:0] out_right
);
    import interp_pkg::*;

    localparam int CH   = 2;
    localparam int RL   = $clog2(R);
    localparam int W1   = IN_W + DROOP_GROWTH;
    localparam int W2   = W1 + HB_GROWTH;
    localparam int W3   = W2 + HB_GROWTH;
    localparam int W4   = W3 + RL + 2;
    localparam int FRAC = DROOP_FRAC + 2 * HB_FRAC + RL;
    localparam logic signed [W4:0] RND_HALF = {{W4{1'b0}}, 1'b1} <<< (FRAC - 1);
    localparam logic signed [W4:0] Q_MAX = {{(W4+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [W4:0] Q_MIN = {{(W4+2-OUT_W){1'b1}}, {(OUT_W-1){1'b0}}};

    logic              v1, r1, v2, r2, v3, r3;
    logic [CH*W1-1:0]  s1;
    logic [CH*W2-1:0]  s2;
    logic [CH*W3-1:0]  s3;
    logic [CH*W4-1:0]  s4;
    logic [OUT_W-1:0]  res [CH];

    droop_eq #(.CH(CH), .IW(IN_W), .OW(W1)) u_eq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data({in_right, in_left}),
        .out_valid(v1), .out_ready(r1), .out_data(s1));

    halfband_x2 #(.CH(CH), .IW(W1), .OW(W2)) u_hb1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v1), .in_ready(r1), .in_data(s1),
        .out_valid(v2), .out_ready(r2), .out_data(s2));

    halfband_x2 #(.CH(CH), .IW(W2), .OW(W3)) u_hb2 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v2), .in_ready(r2), .in_data(s2),
        .out_valid(v3), .out_ready(r3), .out_data(s3));

    comb2_interp #(.CH(CH), .IW(W3), .R(R), .OW(W4)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v3), .in_ready(r3), .in_data(s3),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(s4));

    // Round half up, drop the fraction, clamp to the output range.
    for (genvar c = 0; c < CH; c++) begin : g_out
        logic signed [W4-1:0] v;
        logic signed [W4:0]   rnd, q;
        assign v   = s4[c*W4 +: W4];
        assign rnd = {v[W4-1], v} + RND_HALF;
        assign q   = rnd >>> FRAC;
        assign res[c] = (q > Q_MAX) ? Q_MAX[OUT_W-1:0] :
                        (q < Q_MIN) ? Q_MIN[OUT_W-1:0] : q[OUT_W-1:0];
    end

    assign out_left  = res[0];
    assign out_right = res[1];

    // R9: output words hold under back-pressure.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));
endmodule

// File: tb/tb_interp_chain.sv
`timescale 1ns/1ps
module tb_interp_chain;
    localparam int IN_W  = 18;
    localparam int OUT_W = 18;
    localparam int R     = 32;
    localparam int N     = 40;
    localparam int PER   = 4 * R;
    localparam int TOT   = N * PER;
    localparam int F     = 3 + 4 + 4 + $clog2(R);
    localparam longint OMAX = 131071;
    localparam longint OMIN = -131072;

    // Stimulus table: DC, full-scale steps, Nyquist tone, then mixed values.
    localparam int STIM_L [N] = '{
        1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000,
        131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071,
        20000, -20000, 20000, -20000, 20000, -20000, 20000, -20000,
        -30000, -20000, -10000, 0, 10000, 20000, 30000, 40000, 50000, 60000, 70000, 80000};
    localparam int STIM_R [N] = '{
        -2500, -2500, -2500, -2500, -2500, -2500, -2500, -2500, -2500, -2500,
        -131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072,
        0, 0, 0, 0, 0, 0, 0, 0,
        12345, -777, 0, 64000, -64000, 3, -3, 99999, -99999, 500, -500, 0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_left = '0;
    logic [IN_W-1:0]  in_right = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [OUT_W-1:0] out_left;
    logic [OUT_W-1:0] out_right;

    int nchk = 0;
    int nerr = 0;
    longint expv [2][TOT];
    longint got  [2][TOT];

    always #2.5 clk = ~clk;

    interp_chain #(.IN_W(IN_W), .OUT_W(OUT_W), .R(R)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_left(out_left), .out_right(out_right));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint xin(input int ch, input int n);
        if (n < 0) return 0;
        return (ch == 0) ? longint'(STIM_L[n]) : longint'(STIM_R[n]);
    endfunction

    // Expected streams from the stage equations in R3..R7.
    task automatic build_model(input int ch);
        longint d [N];
        longint u [2*N];
        longint w [4*N];
        for (int n = 0; n < N; n++)                     // R3 equalizer
            d[n] = 10 * xin(ch, n-1) - xin(ch, n) - xin(ch, n-2);
        for (int n = 0; n < N; n++) begin               // R4 first half-band
            longint a0 = d[n];
            longint a1 = (n >= 1) ? d[n-1] : 0;
            longint a2 = (n >= 2) ? d[n-2] : 0;
            longint a3 = (n >= 3) ? d[n-3] : 0;
            u[2*n]   = 16 * a2;
            u[2*n+1] = 9 * (a1 + a2) - (a0 + a3);
        end
        for (int n = 0; n < 2*N; n++) begin             // R4 second half-band
            longint b0 = u[n];
            longint b1 = (n >= 1) ? u[n-1] : 0;
            longint b2 = (n >= 2) ? u[n-2] : 0;
            longint b3 = (n >= 3) ? u[n-3] : 0;
            w[2*n]   = 16 * b2;
            w[2*n+1] = 9 * (b1 + b2) - (b0 + b3);
        end
        for (int k = 0; k < 4*N; k++) begin             // R5 comb, R6 round, R7 clamp
            for (int j = 0; j < R; j++) begin
                longint wp = (k >= 1) ? w[k-1] : 0;
                longint yv = longint'(j + 1) * w[k] + longint'(R - 1 - j) * wp;
                longint z  = (yv + (longint'(1) <<< (F - 1))) >>> F;
                if (z > OMAX) z = OMAX;
                if (z < OMIN) z = OMIN;
                expv[ch][k*R + j] = z;
            end
        end
    endtask

    // Walk the stimulus table once; mode 1 adds input gaps, output stalls.
    task automatic run_stream(input int mode);
        int idx;
        int outn;
        int cyc;
        bit held;
        logic [OUT_W-1:0] hl, hr;
        idx = 0; outn = 0; cyc = 0; held = 1'b0; hl = '0; hr = '0;
        while (outn < TOT && cyc < 40000) begin
            @(negedge clk);
            out_ready = (mode == 0) ? 1'b1 :
                        ((cyc >= 200 && cyc < 500) ? 1'b0 : (cyc % 3 != 2));
            in_valid  = (idx < N) && (mode == 0 || cyc % 5 != 4);
            in_left   = (idx < N) ? IN_W'(STIM_L[idx]) : '0;
            in_right  = (idx < N) ? IN_W'(STIM_R[idx]) : '0;
            #1;
            if (mode == 1 && cyc == 499)
                check(in_ready == 1'b0, "R9 long stall reaches input", in_ready, 0);
            if (out_valid && !out_ready) begin
                if (held) begin
                    check(out_left == hl && out_right == hr, "R9 hold under stall",
                          longint'($signed(out_left)), longint'($signed(hl)));
                end
                held = 1'b1; hl = out_left; hr = out_right;
            end else begin
                held = 1'b0;
            end
            if (out_valid && out_ready) begin
                got[0][outn] = longint'($signed(out_left));
                got[1][outn] = longint'($signed(out_right));
                check(got[0][outn] == expv[0][outn], "R6 left sample (R3 R4 R5 chain)",
                      got[0][outn], expv[0][outn]);
                check(got[1][outn] == expv[1][outn], "R10 right sample",
                      got[1][outn], expv[1][outn]);
                outn++;
            end
            if (in_valid && in_ready) idx++;
            cyc++;
        end
        check(outn == TOT, "R2 output count (watchdog)", outn, TOT);
        check(idx == N, "R2 all inputs accepted", idx, N);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        begin
            bit extra;
            extra = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk); #1;
                if (out_valid) extra = 1'b1;
            end
            check(!extra, "R2 no output beyond 4R per input", extra, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid low in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid low after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready high after reset", in_ready, 1);
    endtask

    initial begin
        longint mx, mn;
        build_model(0);
        build_model(1);

        do_reset();
        run_stream(0);

        // R8: DC level after ten equal samples (index of last output of row 9).
        check(got[0][9*PER + PER-1] == 1000, "R8 DC left", got[0][9*PER + PER-1], 1000);
        check(got[1][9*PER + PER-1] == -2500, "R8 DC right", got[1][9*PER + PER-1], -2500);
        // R7: full-scale steps overshoot and must clamp, not wrap.
        mx = OMIN; mn = OMAX;
        for (int i = 10*PER; i < 20*PER; i++) begin
            if (got[0][i] > mx) mx = got[0][i];
            if (got[1][i] < mn) mn = got[1][i];
        end
        check(mx == OMAX, "R7 positive clamp", mx, OMAX);
        check(mn == OMIN, "R7 negative clamp", mn, OMIN);
        check(got[0][19*PER + PER-1] == OMAX, "R7 settled full scale",
              got[0][19*PER + PER-1], OMAX);

        // R1: a second reset clears history; the repeat run must match again.
        do_reset();
        run_stream(1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule